// File: doc/BRIEF.md
# Direct and Duplex LCD Drive Sequencer

This block turns eight stored segment bytes into drive codes for a 32-segment liquid crystal panel. A slow tick, one per display phase, steps it through a frame. Each tick produces a new level code for two backplane outputs and for every segment output. A separate analog stage turns each code into a real voltage. The codes are low, half supply, high, and undriven.

Two drive schemes share the same eight bytes, chosen by a mode input.

- **Single-backplane scheme:** only the first backplane toggles. Each segment copies it when dark and inverts it when lit. A bank input picks either the even bytes or the odd bytes, so a second picture can wait in storage and be swapped in.
- **Two-backplane, half-bias scheme:** both backplanes take part, and all eight bytes are shown at once. Even bytes give the states against the first backplane and odd bytes the states against the second.

Mode and bank are sampled only when a frame starts. This keeps every frame free of any DC part. A cascade input selects whether the backplanes are held low or left undriven while reset is held.

Top module: `lcd_drive_seq`

## Requirements
- R1: While `rst_n` is low, every segment code is low (00) and the internal phase and latched mode are cleared. Both backplane codes are low (00) when `cascade_en` is 0 and undriven (11) when it is 1. Level codes are 00 low, 01 half supply, 10 high, 11 undriven.
- R2: The outputs are registered. They change only at a clock edge where `tick` is high, and they hold their values at every other edge.
- R3: In the single-backplane scheme (`mode_sel`=0), the frame has two phases. The first backplane is high in phase 0 and low in phase 1. The second backplane is undriven (11) in both phases.
- R4: In the single-backplane scheme, a dark segment (bit 0) carries the same code as the first backplane. A lit segment (bit 1) carries the opposite full level. Over a frame, a lit segment sees full supply rms and a dark one sees zero.
- R5: In the single-backplane scheme, `bank_sel`=0 shows bytes 0, 2, 4 and 6, and `bank_sel`=1 shows bytes 1, 3, 5 and 7.
- R6: Byte k sits at `seg_bytes[8k+7:8k]`. Bit b of bytes 2g and 2g+1 controls segment 8g+b (0-based), whose code is `seg_code[2(8g+b)+1 : 2(8g+b)]`.
- R7: In the two-backplane scheme (`mode_sel`=1), the frame has four phases. The first backplane runs high, half, low, half across phases 0 to 3. The second runs half, high, half, low.
- R8: In the two-backplane scheme, `bank_sel` has no effect. In a phase where one backplane is at full level, the segment takes the opposite full level if its bit for that backplane is 1. Otherwise it takes the same level as that backplane. The even byte's bit is used against the first backplane and the odd byte's bit against the second.
- R9: In the two-backplane scheme, the squared difference against a backplane, summed over one frame in units of quarter supply, is 10 when that bit is 1 and 2 when it is 0. This gives an rms ratio of about 2.236. Against the first backplane, the plain difference summed over a frame is zero in both schemes.
- R10: `mode_sel` and `bank_sel` are sampled only at a tick taken in phase 0. A change made partway through a frame first appears at the next frame, which starts at phase 0.
- R11: A segment code is never half supply or undriven.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle enable that advances one display phase |
| cascade_en | input | 1 | 1: backplanes undriven during reset; 0: backplanes low during reset |
| mode_sel | input | 1 | 0 single-backplane scheme, 1 two-backplane scheme |
| bank_sel | input | 1 | Bank choice for the single-backplane scheme |
| seg_bytes | input | 64 | Eight segment bytes, byte k at bits 8k+7..8k |
| bp1_code | output | 2 | Level code for the first backplane |
| bp2_code | output | 2 | Level code for the second backplane |
| seg_code | output | 64 | Two-bit level code per segment, segment s at bits 2s+1..2s |

## Verification
Every result comes from one register stage. The codes for a phase appear just after the clock edge that takes the tick, and they stay put until the next tick. The bench therefore raises `tick` for one cycle from a falling edge and samples at the following falling edge, which is one edge after the tick was taken.

A mode or bank change made partway through a frame is due only after the remaining phases of that frame. The directed checks step through those phases and expect the old scheme until phase 0 comes round.

The rms and DC sums are gathered over a whole frame before they are compared.

// File: rtl/lcd_drv_pkg.sv
// Package: level codes and shared constants for the LCD drive sequencer.
// Assumes the analog stage decodes LVL_* into low, half-supply, high, or high-Z.
package lcd_drv_pkg;
    localparam int LVL_W = 2;

    typedef enum logic [LVL_W-1:0] {
        LVL_LOW  = 2'b00,
        LVL_MID  = 2'b01,
        LVL_HIGH = 2'b10,
        LVL_OFF  = 2'b11
    } lvl_e;
endpackage

// File: rtl/lcd_phase_seq.sv
// Phase sequencer: counts display phases within a frame and latches the drive
// scheme and bank at the frame start, so a frame never mixes schemes.
// Assumes tick is a single-cycle enable; PH_W must cover four phases.
module lcd_phase_seq #(
    parameter int PH_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            mode_in,
    input  logic            bank_in,
    output logic [PH_W-1:0] phase,
    output logic            eff_mode,
    output logic            eff_bank
);
    localparam logic [PH_W-1:0] LAST_DIRECT = PH_W'(1);
    localparam logic [PH_W-1:0] LAST_DUPLEX = PH_W'(3);

    logic [PH_W-1:0] phase_q;
    logic [PH_W-1:0] phase_nxt;
    logic            mode_q;
    logic            bank_q;
    logic            at_start;
    logic            at_end;

    // Pick live controls at the frame start, latched ones elsewhere.
    always_comb begin
        at_start  = (phase_q == '0);
        eff_mode  = at_start ? mode_in : mode_q;
        eff_bank  = at_start ? bank_in : bank_q;
        at_end    = eff_mode ? (phase_q == LAST_DUPLEX) : (phase_q == LAST_DIRECT);
        phase_nxt = at_end ? '0 : phase_q + PH_W'(1);
    end

    // Advance the phase and capture controls on a frame-start tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
            mode_q  <= 1'b0;
            bank_q  <= 1'b0;
        end else if (tick) begin
            phase_q <= phase_nxt;
            if (at_start) begin
                mode_q <= mode_in;
                bank_q <= bank_in;
            end
        end
    end

    assign phase = phase_q;
endmodule

// File: rtl/lcd_bp_gen.sv
// Backplane level generator: maps the phase and scheme to the two backplane codes.
// Assumes phase stays below 2 in the single-backplane scheme.
module lcd_bp_gen
    import lcd_drv_pkg::*;
#(
    parameter int PH_W = 2
) (
    input  logic [PH_W-1:0] phase,
    input  logic            dplx,
    output lvl_e            bp1,
    output lvl_e            bp2
);
    // Decode backplane levels for the current phase.
    always_comb begin
        bp1 = LVL_LOW;
        bp2 = LVL_OFF;
        if (!dplx) begin
            bp1 = phase[0] ? LVL_LOW : LVL_HIGH;
        end else begin
            case (phase[1:0])
                2'd0:    begin bp1 = LVL_HIGH; bp2 = LVL_MID;  end
                2'd1:    begin bp1 = LVL_MID;  bp2 = LVL_HIGH; end
                2'd2:    begin bp1 = LVL_LOW;  bp2 = LVL_MID;  end
                default: begin bp1 = LVL_MID;  bp2 = LVL_LOW;  end
            endcase
        end
    end
endmodule

// File: rtl/lcd_seg_cell.sv
// Segment cell: computes one segment's full-swing level from its two stored bits.
// Assumes the backplane pattern of lcd_bp_gen: even phases carry BP1 at full
// level, phase bit 1 marks the low half of the frame.
module lcd_seg_cell
    import lcd_drv_pkg::*;
#(
    parameter int PH_W = 2
) (
    input  logic [PH_W-1:0] phase,
    input  logic            dplx,
    input  logic            bank,
    input  logic            bit_even,
    input  logic            bit_odd,
    output lvl_e            lvl
);
    logic sel_bit;
    logic go_low;

    // Choose the governing bit and whether this phase drives low.
    always_comb begin
        if (!dplx) begin
            sel_bit = bank ? bit_odd : bit_even;
            go_low  = phase[0] ^ sel_bit;
        end else begin
            sel_bit = phase[0] ? bit_odd : bit_even;
            go_low  = phase[1] ^ sel_bit;
        end
        lvl = go_low ? LVL_LOW : LVL_HIGH;
    end
endmodule

// File: rtl/lcd_drive_seq.sv
// Top: direct/duplex LCD drive sequencer. Registers backplane and segment
// codes on each tick; reset blanks the segments and parks the backplanes
// low, or undriven when cascade_en is set.
// Assumes seg_bytes is stable around a tick.
module lcd_drive_seq
    import lcd_drv_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter int REG_W    = 8
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   tick,
    input  logic                                   cascade_en,
    input  logic                                   mode_sel,
    input  logic                                   bank_sel,
    input  logic [NUM_REGS*REG_W-1:0]              seg_bytes,
    output logic [LVL_W-1:0]                       bp1_code,
    output logic [LVL_W-1:0]                       bp2_code,
    output logic [(NUM_REGS/2)*REG_W*LVL_W-1:0]    seg_code
);
    localparam int NUM_SEG   = (NUM_REGS / 2) * REG_W;
    localparam int SEG_BUS_W = NUM_SEG * LVL_W;
    localparam int PH_W      = 2;

    logic [PH_W-1:0] phase;
    logic            eff_mode;
    logic            eff_bank;
    lvl_e            bp1_nxt;
    lvl_e            bp2_nxt;
    lvl_e            seg_nxt [NUM_SEG];
    logic [LVL_W-1:0]     bp1_q;
    logic [LVL_W-1:0]     bp2_q;
    logic [SEG_BUS_W-1:0] seg_q;
    logic [LVL_W-1:0]     park_lvl;

    lcd_phase_seq #(.PH_W(PH_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .mode_in  (mode_sel),
        .bank_in  (bank_sel),
        .phase    (phase),
        .eff_mode (eff_mode),
        .eff_bank (eff_bank)
    );

    lcd_bp_gen #(.PH_W(PH_W)) u_bp (
        .phase (phase),
        .dplx  (eff_mode),
        .bp1   (bp1_nxt),
        .bp2   (bp2_nxt)
    );

    for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
        localparam int GRP = s / REG_W;
        localparam int BIT = s % REG_W;
        lcd_seg_cell #(.PH_W(PH_W)) u_cell (
            .phase    (phase),
            .dplx     (eff_mode),
            .bank     (eff_bank),
            .bit_even (seg_bytes[(2*GRP)*REG_W + BIT]),
            .bit_odd  (seg_bytes[(2*GRP+1)*REG_W + BIT]),
            .lvl      (seg_nxt[s])
        );
    end

    // Reset-time backplane level: parked low, or released in cascade use.
    assign park_lvl = cascade_en ? LVL_OFF : LVL_LOW;

    // Register the output codes once per tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bp1_q <= park_lvl;
            bp2_q <= park_lvl;
            seg_q <= '0;
        end else if (tick) begin
            bp1_q <= bp1_nxt;
            bp2_q <= bp2_nxt;
            for (int s = 0; s < NUM_SEG; s++) begin
                seg_q[s*LVL_W +: LVL_W] <= seg_nxt[s];
            end
        end
    end

    assign bp1_code = bp1_q;
    assign bp2_code = bp2_q;
    assign seg_code = seg_q;
endmodule

// File: rtl/lcd_drive_chk.sv
// Checker for lcd_drive_seq: temporal properties on the output codes,
// attached to every instance by the bind below.
module lcd_drive_chk #(
    parameter int SEG_BUS_W = 64,
    parameter int PH_W      = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 tick,
    input logic                 cascade_en,
    input logic                 mode_sel,
    input logic [PH_W-1:0]      phase,
    input logic [1:0]           bp1_code,
    input logic [1:0]           bp2_code,
    input logic [SEG_BUS_W-1:0] seg_code
);
    localparam logic [SEG_BUS_W-1:0] LSB_MASK = {(SEG_BUS_W/2){2'b01}};

    // R1: reset parks segments low and backplanes per cascade_en.
    p_reset_park_r1: assert property (@(posedge clk)
        !rst_n |=> (seg_code == '0) && (bp2_code == bp1_code) &&
                   (bp1_code == ($past(cascade_en) ? 2'b11 : 2'b00)));

    // R2: without a tick the outputs hold.
    p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(seg_code) && $stable(bp1_code) && $stable(bp2_code));

    // R3: a frame-start tick leaves BP2 undriven exactly in the single-backplane scheme.
    p_bp2_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && phase == '0) |=> ((bp2_code == 2'b11) == !$past(mode_sel)));

    // R3: after any tick the first backplane is driven.
    p_bp1_driven_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> bp1_code != 2'b11);

    // R7: every tick moves the phase on.
    p_phase_advance_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> phase != $past(phase));

    // R11: segment codes are always full swing.
    p_seg_full_swing_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_code & LSB_MASK) == '0);
endmodule

bind lcd_drive_seq lcd_drive_chk #(
    .SEG_BUS_W (SEG_BUS_W),
    .PH_W      (PH_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .cascade_en (cascade_en),
    .mode_sel   (mode_sel),
    .phase      (phase),
    .bp1_code   (bp1_code),
    .bp2_code   (bp2_code),
    .seg_code   (seg_code)
);

// File: tb/lcd_drive_seq_bench.sv
// Bench for lcd_drive_seq: table-driven frame checks, then directed tests.
module lcd_drive_seq_bench;
    localparam int NSEG = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        cascade_en = 1'b0;
    logic        mode_sel = 1'b0;
    logic        bank_sel = 1'b0;
    logic [63:0] seg_bytes = '0;
    logic [1:0]  bp1_code;
    logic [1:0]  bp2_code;
    logic [63:0] seg_code;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    lcd_drive_seq u_lcd_drive_seq (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cascade_en(cascade_en),
        .mode_sel(mode_sel), .bank_sel(bank_sel), .seg_bytes(seg_bytes),
        .bp1_code(bp1_code), .bp2_code(bp2_code), .seg_code(seg_code)
    );

    always #10 clk = ~clk;

    // Vectors: {mode, bank, seg_bytes}
    localparam logic [65:0] VECS [0:7] = '{
        {1'b0, 1'b0, 64'h0123_4567_89AB_CDEF},  // R4 R5 even bank
        {1'b0, 1'b1, 64'h0123_4567_89AB_CDEF},  // R5 odd bank
        {1'b0, 1'b1, 64'h0000_0000_0100_0000},  // R6 byte 3 bit 0 -> segment 8
        {1'b1, 1'b0, 64'h0F33_0F33_0F33_0F33},  // R8 R9 all four bit pairs
        {1'b1, 1'b1, 64'h0F33_0F33_0F33_0F33},  // R8 bank ignored
        {1'b1, 1'b0, 64'hA5C3_5A3C_F00F_9966},  // R7 R8 mixed
        {1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF},  // R4 all lit
        {1'b0, 1'b1, 64'h0000_0000_0000_0000}   // R4 all dark
    };

    function automatic logic [1:0] flip(input logic [1:0] l);
        return (l == 2'b10) ? 2'b00 : 2'b10;
    endfunction

    function automatic logic [1:0] exp_bp1(input logic m, input int p);
        if (!m) return (p == 0) ? 2'b10 : 2'b00;
        case (p)
            0: return 2'b10;
            2: return 2'b00;
            default: return 2'b01;
        endcase
    endfunction

    function automatic logic [1:0] exp_bp2(input logic m, input int p);
        if (!m) return 2'b11;
        case (p)
            1: return 2'b10;
            3: return 2'b00;
            default: return 2'b01;
        endcase
    endfunction

    function automatic logic [1:0] exp_seg(input logic m, input logic b, input int p,
                                           input logic [63:0] r, input int s);
        logic ev, od, on;
        logic [1:0] full;
        ev = r[(2*(s/8))*8 + s%8];
        od = r[(2*(s/8)+1)*8 + s%8];
        if (!m) begin
            on = b ? od : ev;
            full = exp_bp1(m, p);
        end else begin
            on = (p % 2 == 0) ? ev : od;
            full = (p % 2 == 0) ? exp_bp1(m, p) : exp_bp2(m, p);
        end
        return on ? flip(full) : full;
    endfunction

    function automatic int lv(input logic [1:0] c);
        return (c == 2'b00) ? 0 : (c == 2'b01) ? 1 : (c == 2'b10) ? 2 : -100;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic do_tick();
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
    endtask

    task automatic check_phase(input string req, input logic m, input logic b,
                               input int p, input logic [63:0] r);
        logic [63:0] es;
        for (int s = 0; s < NSEG; s++) es[2*s +: 2] = exp_seg(m, b, p, r, s);
        chk(req, "bp1", {62'd0, bp1_code}, {62'd0, exp_bp1(m, p)});
        chk(req, "bp2", {62'd0, bp2_code}, {62'd0, exp_bp2(m, p)});
        chk(req, "seg", seg_code, es);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R2 watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : stim
        // R1: reset with cascade set leaves backplanes undriven.
        cascade_en = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1", "cascade bp1", {62'd0, bp1_code}, 64'd3);
        chk("R1", "cascade bp2", {62'd0, bp2_code}, 64'd3);
        chk("R1", "seg blank", seg_code, 64'd0);
        // R1: reset without cascade parks backplanes low.
        cascade_en = 1'b0;
        seg_bytes = '1;
        @(negedge clk);
        @(negedge clk);
        chk("R1", "master bp1", {62'd0, bp1_code}, 64'd0);
        chk("R1", "master bp2", {62'd0, bp2_code}, 64'd0);
        rst_n = 1'b1;
        // R2: no tick, outputs hold the reset values.
        repeat (5) @(negedge clk);
        chk("R2", "idle seg", seg_code, 64'd0);
        chk("R2", "idle bp1", {62'd0, bp1_code}, 64'd0);

        // Table walk: one full frame per vector.
        for (int v = 0; v < 8; v++) begin
            logic m, b;
            logic [63:0] r;
            int nph;
            int sq1 [NSEG];
            int sq2 [NSEG];
            int dc1 [NSEG];
            int bad;
            {m, b, r} = VECS[v];
            mode_sel = m; bank_sel = b; seg_bytes = r;
            nph = m ? 4 : 2;
            for (int s = 0; s < NSEG; s++) begin sq1[s] = 0; sq2[s] = 0; dc1[s] = 0; end
            for (int p = 0; p < nph; p++) begin
                do_tick();
                check_phase(m ? "R7/R8" : "R3/R4/R5/R6", m, b, p, r);
                for (int s = 0; s < NSEG; s++) begin
                    int d1, d2;
                    d1 = lv(bp1_code) - lv(seg_code[2*s +: 2]);
                    d2 = lv(bp2_code) - lv(seg_code[2*s +: 2]);
                    sq1[s] += d1 * d1;
                    sq2[s] += d2 * d2;
                    dc1[s] += d1;
                end
            end
            // R4/R9: rms and DC sums over the frame.
            bad = 0;
            for (int s = 0; s < NSEG; s++) begin
                logic ev, od;
                int e1, e2;
                ev = r[(2*(s/8))*8 + s%8];
                od = r[(2*(s/8)+1)*8 + s%8];
                if (!m) begin
                    e1 = (b ? od : ev) ? 8 : 0;
                    if (sq1[s] != e1) bad++;
                end else begin
                    e1 = ev ? 10 : 2;
                    e2 = od ? 10 : 2;
                    if (sq1[s] != e1 || sq2[s] != e2) bad++;
                end
                if (dc1[s] != 0) bad++;
            end
            chk(m ? "R9" : "R4", "rms/dc mismatching segments", 64'(bad), 64'd0);
        end

        // R2: after a frame, outputs hold without ticks.
        begin
            logic [63:0] hold_seg;
            hold_seg = seg_code;
            seg_bytes = 64'h1234_5678_9ABC_DEF0;
            repeat (4) @(negedge clk);
            chk("R2", "hold seg", seg_code, hold_seg);
        end

        // R10: mode change partway through a duplex frame.
        seg_bytes = 64'h0F33_0F33_0F33_0F33;
        mode_sel = 1'b1; bank_sel = 1'b0;
        do_tick(); // phase 0, duplex
        do_tick(); // phase 1
        mode_sel = 1'b0; bank_sel = 1'b1;
        do_tick();
        chk("R10", "duplex kept ph2 bp1", {62'd0, bp1_code}, 64'd0);
        chk("R10", "duplex kept ph2 bp2", {62'd0, bp2_code}, 64'd1);
        do_tick();
        chk("R10", "duplex kept ph3 bp2", {62'd0, bp2_code}, 64'd0);
        do_tick(); // new frame, direct, bank 1
        chk("R10", "direct ph0 bp2", {62'd0, bp2_code}, 64'd3);
        chk("R10", "direct bank1 seg2 lit", {62'd0, seg_code[5:4]}, 64'd0);
        bank_sel = 1'b0;
        do_tick(); // phase 1: bank 1 still holds
        chk("R10", "bank held ph1 seg2", {62'd0, seg_code[5:4]}, 64'd2);
        do_tick(); // phase 0: bank 0, segment 2 dark
        chk("R10", "bank0 ph0 seg2", {62'd0, seg_code[5:4]}, 64'd2);
        chk("R11", "no mid or off seg", seg_code & {32{2'b01}}, 64'd0);

        // R1: reset again mid-run clears the outputs.
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk);
        chk("R1", "rerun seg", seg_code, 64'd0);
        chk("R1", "rerun bp1", {62'd0, bp1_code}, 64'd0);
        @(negedge clk) rst_n = 1'b1;
        // R1: phase restarts at 0 after reset; duplex phase 0 has BP1 high.
        mode_sel = 1'b1;
        do_tick();
        chk("R1", "phase zero after reset", {62'd0, bp1_code}, 64'd2);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule